// File: doc/BRIEF.md
# Dual-Length Serial Load Port for a 16-Channel Driver

This block is the serial front end of a 16-channel current-sink driver. A host drives four slow pins: a shift clock, a data line, a latch strobe and a mode select. The block samples all four into a faster system clock through synchronizer stages and detects their rising edges there. The mode select picks one of two shift paths. With mode low, the active path is 16 bits long and carries one on/off bit per channel. With mode high, the active path is 112 bits long and carries a 7-bit current-correction code for each of the 16 channels.

A rising edge on the latch strobe commits the active shift path into its own holding register. In on/off mode, the same edge also loads the pending open-load flags into the 16-bit shift path. The next transfer then shifts those flags out on the serial output while new data shifts in. The serial output always shows the last stage of the path that the mode selects, so several devices can be chained with one device's output feeding the next device's data input. The two holding registers are the outputs of the block. Current generation is not part of this block.

Top module: `ser_load_port`

## Requirements
- R1: While reset is asserted, and directly after it is released, both holding registers read zero and the serial output is 0. Reset also clears both shift paths.
- R2: With mode low, every detected rising shift-clock edge shifts the data bit into bit 0 of the 16-bit path, most significant bit first. After 16 shifts and a latch, the first bit sent sits in `onoff_q[15]` and bit k controls channel k.
- R3: With mode high, every detected rising shift-clock edge shifts into the 112-bit path, most significant bit first. After a latch, channel k's code is `corr_q[7k+6:7k]`, and the first of the 112 bits sent lands in bit 111, which is bit 6 of channel 15.
- R4: A latch rising edge with mode low copies the 16-bit path into `onoff_q` and leaves `corr_q` unchanged.
- R5: A latch rising edge with mode high copies the 112-bit path into `corr_q` and leaves `onoff_q` and the 16-bit path unchanged.
- R6: A latch rising edge with mode low loads `open_flags_i` into the 16-bit path, with a 1 for each open channel. The flags then appear on the serial output, bit 15 first, one bit per later shift.
- R7: The serial output is bit 15 of the 16-bit path when mode is low and bit 111 of the 112-bit path when mode is high. A bit sent with mode low therefore comes out again 16 shifts later.
- R8: A change of mode in the middle of a transfer does not disturb either path. Each path keeps its partial contents, and neither holding register changes until a latch edge arrives.
- R9: Shift-clock edges alone never change either holding register.
- R10: If a shift-clock rising edge and a latch rising edge are detected in the same system cycle, the latch takes effect and the shift is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on / undervoltage-recovery reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdin_i | input | 1 | Serial data in (asynchronous) |
| latch_i | input | 1 | Latch strobe, acts on its rising edge (asynchronous) |
| sel_i | input | 1 | Mode: 0 selects the 16-bit on/off path, 1 the 112-bit correction path |
| open_flags_i | input | CHANNELS | Pending open-load flags, one per channel, synchronous to clk |
| sdout_o | output | 1 | Serial output, last stage of the selected path |
| onoff_q | output | CHANNELS | On/off holding register, bit k is channel k |
| corr_q | output | CHANNELS*CODE_W | Correction holding register, channel k at bits 7k+6..7k |

## Verification
The bench looks at bit order at the path ends. A reversed shift direction would put the first bit sent into bit 0 instead of bit 15 or bit 111. It switches mode in the middle of a frame, which a shared or cleared path would corrupt. It checks the flags that come back after an on/off latch bit by bit on the serial output. A design that latched without reloading would send the old data back, and one that reloaded in correction mode would lose on/off data. It also drives a shift edge and a latch edge together. A design that shifted first would commit a frame moved over by one bit.

// File: rtl/ser_load_port.sv
module ser_load_port #(
  parameter int CHANNELS    = 16,
  parameter int CODE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk_i,
  input  logic                         sdin_i,
  input  logic                         latch_i,
  input  logic                         sel_i,
  input  logic [CHANNELS-1:0]          open_flags_i,
  output logic                         sdout_o,
  output logic [CHANNELS-1:0]          onoff_q,
  output logic [CHANNELS*CODE_W-1:0]   corr_q
);
  localparam int ON_W   = CHANNELS;
  localparam int CORR_W = CHANNELS * CODE_W;
  localparam int SY_W   = 4 * SYNC_STAGES;

  logic [SY_W-1:0]   sync_q;
  logic              sclk_s, sd_s, lat_s, mode_s;
  logic              sclk_d, lat_d;
  logic              clk_rise, lat_rise;
  logic [ON_W-1:0]   onoff_sh;
  logic [CORR_W-1:0] corr_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SY_W-5:0], sel_i, latch_i, sdin_i, sclk_i};

  assign {mode_s, lat_s, sd_s, sclk_s} = sync_q[SY_W-1 -: 4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b0;
      lat_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      lat_d  <= lat_s;
    end

  assign clk_rise = sclk_s & ~sclk_d;
  assign lat_rise = lat_s & ~lat_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      onoff_sh <= '0;
      corr_sh  <= '0;
      onoff_q  <= '0;
      corr_q   <= '0;
    end else if (lat_rise) begin
      if (mode_s) corr_q <= corr_sh;
      else begin
        onoff_q  <= onoff_sh;
        onoff_sh <= open_flags_i;
      end
    end else if (clk_rise) begin
      if (mode_s) corr_sh  <= {corr_sh[CORR_W-2:0], sd_s};
      else        onoff_sh <= {onoff_sh[ON_W-2:0], sd_s};
    end

  assign sdout_o = mode_s ? corr_sh[CORR_W-1] : onoff_sh[ON_W-1];
endmodule

// File: rtl/ser_load_port_chk.sv
module ser_load_port_chk #(
  parameter int ON_W   = 16,
  parameter int CORR_W = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_rise,
  input logic              lat_rise,
  input logic              mode_s,
  input logic              sd_s,
  input logic [ON_W-1:0]   open_flags_i,
  input logic [ON_W-1:0]   onoff_sh,
  input logic [CORR_W-1:0] corr_sh,
  input logic [ON_W-1:0]   onoff_q,
  input logic [CORR_W-1:0] corr_q
);
  // R2
  onoff_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && !lat_rise && !mode_s) |=> onoff_sh == {$past(onoff_sh[ON_W-2:0]), $past(sd_s)});
  // R4
  onoff_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !mode_s) |=> onoff_q == $past(onoff_sh));
  // R6
  flag_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !mode_s) |=> onoff_sh == $past(open_flags_i));
  // R5
  corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_rise && mode_s) |=> $stable(corr_q));
  // R9
  onoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_rise && !mode_s) |=> $stable(onoff_q));
  // R8
  onoff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |=> $stable(onoff_sh));
  // R8
  corr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> $stable(corr_sh));
endmodule

bind ser_load_port ser_load_port_chk #(.ON_W(CHANNELS), .CORR_W(CHANNELS*CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .lat_rise(lat_rise),
  .mode_s(mode_s), .sd_s(sd_s), .open_flags_i(open_flags_i),
  .onoff_sh(onoff_sh), .corr_sh(corr_sh), .onoff_q(onoff_q), .corr_q(corr_q));

// File: tb/ser_load_port_bench.sv
module ser_load_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int NCH = 16;
  localparam int CW = 7;
  localparam int NC = NCH * CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, latch = 1'b0, sel = 1'b0;
  logic [NCH-1:0] flags = '0;
  logic sdout;
  logic [NCH-1:0] onoff_q;
  logic [NC-1:0] corr_q;

  logic [NCH-1:0] m_on_sh, m_on_q;
  logic [NC-1:0]  m_corr_sh, m_corr_q;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_load_port u_ser_load_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .latch_i(latch),
    .sel_i(sel), .open_flags_i(flags), .sdout_o(sdout), .onoff_q(onoff_q), .corr_q(corr_q));

  function automatic logic exp_sdout();
    return sel ? m_corr_sh[NC-1] : m_on_sh[NCH-1];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin = b; sclk = 1'b0; waitn(HOLD);
    sclk = 1'b1; waitn(HOLD);
    if (sel) m_corr_sh = {m_corr_sh[NC-2:0], b};
    else     m_on_sh   = {m_on_sh[NCH-2:0], b};
    chk("R7 sdout", {127'd0, sdout}, {127'd0, exp_sdout()});
  endtask

  task automatic do_latch();
    sclk = 1'b0; latch = 1'b1; waitn(HOLD);
    latch = 1'b0; waitn(HOLD);
    if (sel) m_corr_q = m_corr_sh;
    else begin m_on_q = m_on_sh; m_on_sh = flags; end
  endtask

  task automatic set_mode(input logic m);
    sel = m; waitn(HOLD);
  endtask

  task automatic check_q(input string req);
    chk(req, {112'd0, onoff_q}, {112'd0, m_on_q});
    chk(req, {16'd0, corr_q}, {16'd0, m_corr_q});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [NC-1:0] frame;
    void'($urandom(32'd4711));
    m_on_sh = '0; m_on_q = '0; m_corr_sh = '0; m_corr_q = '0;
    waitn(3);
    // R1 during reset
    chk("R1 onoff_q in reset", {112'd0, onoff_q}, 128'd0);
    chk("R1 corr_q in reset", {16'd0, corr_q}, 128'd0);
    rst_n = 1'b1; waitn(HOLD);
    chk("R1 sdout after reset", {127'd0, sdout}, 128'd0);
    check_q("R1 holding after reset");

    // R2 directed: first bit lands in bit 15
    send_bit(1'b1);
    for (int i = 0; i < NCH-1; i++) send_bit(1'b0);
    check_q("R9 no change before latch");
    do_latch();
    chk("R2 first bit in onoff_q[15]", {112'd0, onoff_q}, 128'h8000);
    check_q("R4 onoff latch");

    // R3 directed: first of 112 bits lands in bit 111
    set_mode(1'b1);
    send_bit(1'b1);
    for (int i = 0; i < NC-1; i++) send_bit(1'b0);
    do_latch();
    chk("R3 first bit at ch15 bit6", {16'd0, corr_q}, {16'd0, 1'b1, 111'd0});
    chk("R5 onoff_q untouched", {112'd0, onoff_q}, 128'h8000);

    // R3 channel fields: channel k code = k+1
    for (int k = NCH-1; k >= 0; k--)
      for (int b = CW-1; b >= 0; b--) send_bit(1'(((k + 1) >> b) & 1));
    do_latch();
    for (int k = 0; k < NCH; k++)
      chk("R3 channel field", {121'd0, corr_q[CW*k +: CW]}, 128'(k + 1));

    // R6 flag reload and readback
    set_mode(1'b0);
    flags = 16'hA5C3;
    for (int i = 0; i < NCH; i++) send_bit(1'($urandom_range(0, 1)));
    do_latch();
    check_q("R4 commit with flags pending");
    chk("R6 flag bit15 on sdout", {127'd0, sdout}, {127'd0, flags[15]});
    for (int i = 0; i < NCH; i++) send_bit(1'b0);
    do_latch();
    check_q("R6 readback frame");

    // R8 mode change mid transfer
    flags = 16'h0F0F; do_latch();
    for (int i = 0; i < 5; i++) send_bit(1'($urandom_range(0, 1)));
    set_mode(1'b1);
    for (int i = 0; i < 30; i++) send_bit(1'($urandom_range(0, 1)));
    check_q("R8 no latch mid transfer");
    set_mode(1'b0);
    for (int i = 0; i < 11; i++) send_bit(1'($urandom_range(0, 1)));
    do_latch();
    check_q("R8 onoff after mode switch");
    set_mode(1'b1);
    for (int i = 0; i < NC-30; i++) send_bit(1'($urandom_range(0, 1)));
    do_latch();
    check_q("R8 corr after mode switch");

    // R10 shift and latch together: latch wins
    set_mode(1'b0);
    sclk = 1'b0; sdin = 1'b1; waitn(HOLD);
    sclk = 1'b1; latch = 1'b1; waitn(HOLD);
    m_on_q = m_on_sh; m_on_sh = flags;
    sclk = 1'b0; latch = 1'b0; waitn(HOLD);
    check_q("R10 latch wins over shift");
    chk("R10 sdout from flags", {127'd0, sdout}, {127'd0, flags[15]});

    // random frames in both modes
    for (int it = 0; it < 6; it++) begin
      logic m;
      m = 1'($urandom_range(0, 1));
      set_mode(m);
      flags = 16'($urandom);
      for (int w = 0; w < 4; w++) frame[32*w +: 32] = $urandom;
      for (int i = (m ? NC : NCH) - 1; i >= 0; i--) send_bit(frame[i]);
      do_latch();
      check_q(m ? "R5 random corr frame" : "R4 random onoff frame");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule